// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

The block is a memory-mapped watchdog with two 32-bit registers: a control word and a timer word. Software loads a tick count into the timer word. While the control word holds a non-zero action code, the count steps down by one on every watchdog tick. Each later write to the timer word reloads it, which is how software shows it is still alive. If the count runs down to zero, the block fires the chosen action: nothing, a one-cycle general interrupt pulse, a one-cycle non-maskable interrupt pulse, or a chip-reset request that stays high until the chip reset arrives.

A reset-cause bit at the top of the control word tells software, after a restart, whether the watchdog caused that restart. Two reset inputs make this work. The chip reset, which the watchdog's own request triggers, clears everything except that bit. The power-on reset also clears the bit.

Top module: `guard_timer`

## Requirements
- R1: The control word is at byte offset 0x0 and the timer word at offset 0x4. Reading any other offset returns 0, and writes to any other offset change nothing.
- R2: While either reset is low, and after it is released, the action code is 0, the count is 0 and all three action outputs are low.
- R3: A timer write loads the low CNT_W bits of the write data. Reading the timer word returns the current count, zero-extended to 32 bits.
- R4: The count drops by exactly one on each clock cycle where the tick input is high and the action code is non-zero. It does not change on cycles without a tick.
- R5: Expiry is the decrement that takes the count from 1 to 0. After that the count stays at 0 and no further action fires until a reload.
- R6: With action code 1, expiry drives `irqPulse` high for one cycle. The pulse appears in the cycle in which the count first reads 0.
- R7: With action code 2, expiry drives `nmiPulse` high for one cycle, with the same timing as R6.
- R8: With action code 3, expiry raises `chipRstReq`, and it stays high until `rstN` or `porN` goes low.
- R9: Control bit 31 reads 1 from the cycle `chipRstReq` rises. `rstN` does not clear it. Only `porN` clears it.
- R10: If a timer write lands on the cycle in which expiry would happen, the write wins: the count reloads and no action fires.
- R11: Control bits [1:0] hold the action code. Writes to bits [31:2] are ignored, and bits [30:2] always read 0.
- R12: Writing action code 0 in the middle of a countdown freezes the count and stops any action from firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rstN | input | 1 | Chip reset, active low, asynchronous; leaves the reset-cause bit alone |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| tick | input | 1 | Watchdog tick enable, one decrement per high cycle |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the addressed word (combinational) |
| irqPulse | output | 1 | One-cycle general interrupt on expiry |
| nmiPulse | output | 1 | One-cycle non-maskable interrupt on expiry |
| chipRstReq | output | 1 | Chip-reset request level |

## Verification
The bench builds the block with CNT_W = 12, so the counter is 12 bits wide. This lets a write of all ones show truncation to the full-scale count of 4095. It also keeps a run to expiry from the top of the range short enough to simulate. Because ADDR_W stays at 4, there are unused offsets the bench can write and read. The tick runs every cycle in some phases and every third cycle in others. Timer writes are placed on the exact expiry cycle, so the write-wins rule is tested right at the 1-to-0 step.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FLAG_BIT = 31;

  typedef enum logic [1:0] {
    ACT_OFF   = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_RESET = 2'd3
  } action_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic dec;
  } cnt_strb_t;
endpackage

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             arstN,
  input  cnt_strb_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             atOne,
  output logic             atZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)         count <= '0;
    else if (strb.load) count <= loadVal;
    else if (strb.dec)  count <= count - ONE;
  end

  assign atOne  = (count == ONE);
  assign atZero = (count == '0);
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              porN,
  input  logic              tick,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              atOne,
  input  logic              atZero,
  output cnt_strb_t         strb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqPulse,
  output logic              nmiPulse,
  output logic              chipRstReq,
  output logic              lastRst
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_TIMER = ADDR_W'(4);

  action_e action;
  logic    wrEn, wrCtrl, wrTimer, armed, expire;
  logic [DATA_W-1:0] ctrlWord, timerWord;

  assign wrEn    = regValid && regWrite;
  assign wrCtrl  = wrEn && (regAddr == OFS_CTRL);
  assign wrTimer = wrEn && (regAddr == OFS_TIMER);
  assign armed   = (action != ACT_OFF);

  // a reload always beats a decrement, so expiry cannot coincide with a write
  assign strb.load = wrTimer;
  assign strb.dec  = tick && armed && !atZero && !wrTimer;
  assign expire    = strb.dec && atOne;
  assign loadVal   = regWdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)      action <= ACT_OFF;
    else if (wrCtrl) action <= action_e'(regWdata[1:0]);
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      irqPulse   <= 1'b0;
      nmiPulse   <= 1'b0;
      chipRstReq <= 1'b0;
    end else begin
      irqPulse <= expire && (action == ACT_IRQ);
      nmiPulse <= expire && (action == ACT_NMI);
      if (expire && (action == ACT_RESET)) chipRstReq <= 1'b1;
    end
  end

  // reset-cause bit lives in the power-on domain only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) lastRst <= 1'b0;
    else if (expire && (action == ACT_RESET)) lastRst <= 1'b1;
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[FLAG_BIT] = lastRst;
    ctrlWord[1:0]      = action;
  end

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign timerWord = {{(DATA_W-CNT_W){1'b0}}, count};
    end else begin : g_full
      assign timerWord = count;
    end
  endgenerate

  always_comb begin
    if (regAddr == OFS_CTRL)       regRdata = ctrlWord;
    else if (regAddr == OFS_TIMER) regRdata = timerWord;
    else                           regRdata = '0;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              tick,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqPulse,
  output logic              nmiPulse,
  output logic              chipRstReq
);
  logic             arstN, atOne, atZero, lastRst;
  logic [CNT_W-1:0] curCount, loadVal;
  cnt_strb_t        strb;

  assign arstN = rstN & porN;

  guard_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .arstN(arstN), .porN(porN), .tick(tick),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .count(curCount), .atOne(atOne), .atZero(atZero),
    .strb(strb), .loadVal(loadVal), .regRdata(regRdata),
    .irqPulse(irqPulse), .nmiPulse(nmiPulse), .chipRstReq(chipRstReq),
    .lastRst(lastRst)
  );

  guard_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .arstN(arstN), .strb(strb), .loadVal(loadVal),
    .count(curCount), .atOne(atOne), .atZero(atZero)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              porN,
  input logic              tick,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  count,
  input logic              irqPulse,
  input logic              nmiPulse,
  input logic              chipRstReq,
  input logic              lastRst
);
  logic wrT;
  assign wrT = regValid && regWrite && (regAddr == ADDR_W'(4));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (!tick && !wrT) |=> $stable(count));
  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (count == '0 && !wrT) |=> (count == '0));
  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rstN || !porN)
    $onehot0({irqPulse, nmiPulse}));
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN || !porN)
    irqPulse |=> !irqPulse);
  assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN || !porN)
    irqPulse |-> (count == '0));
  assert_nmi_single_R7: assert property (@(posedge clk) disable iff (!rstN || !porN)
    nmiPulse |=> !nmiPulse);
  assert_req_level_R8: assert property (@(posedge clk) disable iff (!rstN || !porN)
    chipRstReq |=> chipRstReq);
  assert_flag_with_req_R9: assert property (@(posedge clk) disable iff (!rstN || !porN)
    chipRstReq |-> lastRst);
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN || !porN)
    wrT |=> (!irqPulse && !nmiPulse));
endmodule

bind guard_timer guard_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .tick(tick), .regValid(regValid),
  .regWrite(regWrite), .regAddr(regAddr), .count(curCount),
  .irqPulse(irqPulse), .nmiPulse(nmiPulse), .chipRstReq(chipRstReq),
  .lastRst(lastRst)
);

// File: tb/guard_timer_tb.sv
`timescale 1ns/100ps
module guard_timer_tb;
  localparam int CW = 12;
  localparam logic [31:0] MASK = (32'd1 << CW) - 1;

  logic clk = 0, rstN = 0, porN = 0, tick = 0;
  logic regValid = 0, regWrite = 0;
  logic [3:0]  regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic irqPulse, nmiPulse, chipRstReq;

  int total = 0, bad = 0, irqSeen = 0, nmiSeen = 0;
  int tickMode = 0;  // 0 off, 1 every cycle, 3 every third cycle
  int phase = 0;
  bit done = 0;

  // reference model state
  logic [1:0]  mAct = 0;
  logic [31:0] mCnt = 0;
  logic mIrq = 0, mNmi = 0, mReq = 0, mFlag = 0;

  always #2 clk = ~clk;  // 250 MHz

  guard_timer #(.ADDR_W(4), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .tick(tick), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqPulse(irqPulse), .nmiPulse(nmiPulse),
    .chipRstReq(chipRstReq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit wrT, wrC, expire;
    if (!porN) begin
      mAct = 0; mCnt = 0; mIrq = 0; mNmi = 0; mReq = 0; mFlag = 0;
    end else if (!rstN) begin
      mAct = 0; mCnt = 0; mIrq = 0; mNmi = 0; mReq = 0;
    end else begin
      wrT = regValid && regWrite && regAddr == 4;
      wrC = regValid && regWrite && regAddr == 0;
      expire = tick && mAct != 0 && mCnt == 1 && !wrT;
      mIrq = expire && mAct == 1;
      mNmi = expire && mAct == 2;
      if (expire && mAct == 3) begin mReq = 1; mFlag = 1; end
      if (wrT) mCnt = regWdata & MASK;
      else if (tick && mAct != 0 && mCnt != 0) mCnt = mCnt - 1;
      if (wrC) mAct = regWdata[1:0];
    end
  end

  function automatic logic [31:0] expRd();
    if (regAddr == 0) return {mFlag, 29'd0, mAct};
    if (regAddr == 4) return mCnt;
    return 0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (irqPulse === 1'b1) irqSeen++;
    if (nmiPulse === 1'b1) nmiSeen++;
    if (!done) begin
      chk({31'd0, irqPulse}, {31'd0, mIrq}, "R6 irqPulse");
      chk({31'd0, nmiPulse}, {31'd0, mNmi}, "R7 nmiPulse");
      chk({31'd0, chipRstReq}, {31'd0, mReq}, "R8 chipRstReq");
      if (rstN && porN) chk(regRdata, expRd(), "R1/R3 regRdata");
    end
  end

  // tick generator
  always @(negedge clk) begin
    #1;
    phase++;
    tick <= (tickMode == 1) || (tickMode == 3 && phase % 3 == 0);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); #1;
    regValid = 0; regWrite = 0; regAddr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    regValid = 1; regWrite = 0; regAddr = a;
    #0.5 chk(regRdata, exp, tag);
    @(negedge clk); #1;
    regValid = 0; regAddr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int i0;
    idle(3); #1 porN = 1; rstN = 1;
    // R2: reset state
    rd(0, 0, "R2 ctrl after reset");
    rd(4, 0, "R2 timer after reset");
    chk({29'd0, irqPulse, nmiPulse, chipRstReq}, 0, "R2 outputs after reset");

    // R3 load, R4 hold without action
    wr(4, 10); tickMode = 1; idle(5);
    rd(4, 10, "R4 no decrement while action 0");
    tickMode = 0; idle(2);
    wr(4, 32'hFFFF_FFFF);
    rd(4, MASK, "R3 load truncated to CNT_W");

    // R6: interrupt on expiry, every-cycle tick
    wr(4, 5); wr(0, 1); i0 = irqSeen; tickMode = 1; idle(12);
    chk(irqSeen - i0, 1, "R6 exactly one irq pulse");
    rd(4, 0, "R5 count holds at zero");
    idle(5);
    chk(irqSeen - i0, 1, "R5 no repeat event at zero");

    // R4 sparse ticks, R7 NMI
    tickMode = 3; wr(0, 2); wr(4, 6); i0 = nmiSeen; idle(30);
    chk(nmiSeen - i0, 1, "R7 exactly one nmi pulse");

    // R12: disable mid-countdown
    tickMode = 0; idle(2);
    wr(4, 40); tickMode = 1; idle(5);
    wr(0, 0); idle(3);
    tickMode = 0; idle(2);
    rd(4, 40 - 7, "R12 count frozen after action 0");
    tickMode = 1; i0 = nmiSeen + irqSeen; idle(50);
    chk(nmiSeen + irqSeen - i0, 0, "R12 no event after disable");

    // R10: keepalive writes landing on the expiry cycle
    tickMode = 0; idle(2); wr(0, 1); tickMode = 1; idle(2);
    i0 = irqSeen;
    for (int k = 0; k < 6; k++) wr(4, 2);
    chk(irqSeen - i0, 0, "R10 write wins over expiry");
    idle(6);
    chk(irqSeen - i0, 1, "R10 expiry once keepalive stops");

    // R11 / R1: ignored bits and unused offsets
    tickMode = 0; idle(2);
    wr(0, 32'hFFFF_FFFC);
    rd(0, 0, "R11 upper control bits ignored");
    wr(4, 77); wr(8, 5); wr(12, 32'hFFFF_FFFF);
    rd(8, 0, "R1 unused offset reads zero");
    rd(4, 77, "R1 unused offset write has no effect");
    rd(0, 0, "R1 control unchanged by unused offset");

    // R8 / R9: reset request and cause flag
    wr(4, 4); wr(0, 3); tickMode = 1; idle(10);
    chk({31'd0, chipRstReq}, 1, "R8 request raised");
    idle(5);
    chk({31'd0, chipRstReq}, 1, "R8 request held");
    rd(0, 32'h8000_0003, "R9 flag set with request");
    tickMode = 0;
    @(negedge clk); #1 rstN = 0; idle(2); #1 rstN = 1;
    idle(1);
    chk({31'd0, chipRstReq}, 0, "R8 request cleared by chip reset");
    rd(0, 32'h8000_0000, "R9 flag survives chip reset");
    wr(0, 0);
    rd(0, 32'h8000_0000, "R11 bit 31 not writable");
    @(negedge clk); #1 porN = 0; idle(2); #1 porN = 1;
    rd(0, 0, "R9 flag cleared by power-on reset");

    idle(3);
    finishRun();
  end
endmodule